// File: doc/BRIEF.md
# Time-of-Day Capable Up/Down Timer

This block is a 32-bit counter that counts up or down by one on each qualified tick. Software reaches it through a few plain write strobes and readback buses. Four clock sources are available: the core clock, a slow crystal clock, and two external pins. The external sources are synchronised and turned into one-cycle enables. A power-of-two prescaler then divides the selected enable stream into count ticks.

The count can be a plain binary value. It can also be a wall-clock style value: four byte-wide fields for hours, minutes, seconds and hundredths, where carries and borrows move between fields. The hour field wraps after either 23 or 255. In periodic mode the counter reloads from the load register at terminal count. In free-running mode it wraps. Either way a sticky interrupt is raised, and it stays high until software writes the clear strobe.

A capture unit watches one of 32 event inputs. When capture is enabled, a rising edge on the selected event copies the live count into the capture register.

Top module: `tod_timer`

## Requirements
- R1: After reset, the current value reads 0xFFFFFFFF. The load value, control word, capture value and interrupt all read zero.
- R2: A load write (`ld_we`) updates the load register and sets the current value to the written data in the same clock edge. It takes priority over a count tick.
- R3: The control word fields are: bit 0 enable, bit 1 up, bit 2 periodic, bits 4:3 format, bits 8:5 prescale code, bits 11:9 source, bit 12 capture enable, bits 17:13 event index. With source 000 and prescale 0000, a binary down count steps by one every cycle. In free-running mode a tick at zero wraps the value to 0xFFFFFFFF and sets `irq`.
- R4: A binary up count in periodic mode reloads the load value on the tick taken at 0xFFFFFFFF, and sets `irq`.
- R5: A binary down count in periodic mode reloads the load value on the tick taken at zero, and sets `irq`.
- R6: The prescale code n divides the source enables by 2^n (code 0100 is 16, 1111 is 32768). The divider restarts each time the timer is disabled.
- R7: While the enable bit is clear and no load write happens, the current value does not change.
- R8: Format 10 or 11 splits the value into hours [31:24], minutes [23:16], seconds [15:8] and hundredths [7:0]. Counting down, a field at zero reloads to its maximum (99, 59, 59) and borrows from the next field. Zero in every field is the down terminal count.
- R9: Counting up in a time format, hundredths wrap after 99, and seconds and minutes wrap after 59, each carrying into the next field. Hours wrap after 23 in format 10 and after 255 in format 11. The all-maximum value is the up terminal count.
- R10: Source 001 counts rising edges of `xtal_clk`, 010 of `pin_a`, and 011 of `pin_b`. Each input passes through two synchronising flip-flops, so a held-high level counts once. Source codes 100 to 111 produce no ticks.
- R11: With capture enabled, a rising edge on `evt_in[index]` copies the current value into the capture register. Edges on other event lines, or any edge while capture is disabled, leave it unchanged. A capture write (`cap_we`) sets the register directly.
- R12: A write on `clri_we` clears `irq`. If a terminal count occurs in the same cycle, `irq` stays set.
- R13: Format 01 counts as plain binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Load register write strobe |
| ld_wdata | input | 32 | Load write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 18 | Control word write data |
| clri_we | input | 1 | Interrupt clear strobe (data ignored) |
| cap_we | input | 1 | Capture register write strobe |
| cap_wdata | input | 32 | Capture write data |
| xtal_clk | input | 1 | Slow crystal clock, sampled as a source |
| pin_a | input | 1 | External count pin A |
| pin_b | input | 1 | External count pin B |
| evt_in | input | 32 | Capture event lines |
| cur_val | output | 32 | Current count value |
| ld_val | output | 32 | Load register readback |
| ctl_val | output | 18 | Control word readback |
| cap_val | output | 32 | Capture register readback |
| irq | output | 1 | Sticky terminal-count interrupt |

## Verification
The bench aims at the field boundaries of the time formats. A one-tick step from 01:00:00:00 down, and from 23:59:59:99 up under both hour limits, exposes a design that lets a field pass 99 or 59, or that uses the wrong hour limit. The terminal counts get the same treatment in both directions and both modes. A wrong terminal value or reload choice shows up as a wrong value or a missing interrupt at an exact cycle. Exact cycle counts at prescale 16 catch a divider that is off by one. Holding a pin high across several cycles catches level counting instead of edge counting. The capture and clear tests use an unselected event line and a clear that collides with a terminal count. Those catch a capture that fires on the wrong line, and a clear that wins over a set.

// File: rtl/tod_timer_pkg.sv
package tod_timer_pkg;
  localparam int VAL_W     = 32;
  localparam int EVT_N     = 32;
  localparam int EVT_SEL_W = $clog2(EVT_N);
  localparam int PSC_W     = 4;
  localparam int PSC_CNT_W = 15;
  localparam int SRC_W     = 3;
  localparam int CTL_W     = EVT_SEL_W + 1 + SRC_W + PSC_W + 2 + 3;

  localparam logic [SRC_W-1:0] SRC_CORE = 3'd0;
  localparam logic [SRC_W-1:0] SRC_XTAL = 3'd1;
  localparam logic [SRC_W-1:0] SRC_PINA = 3'd2;
  localparam logic [SRC_W-1:0] SRC_PINB = 3'd3;

  typedef enum logic [1:0] {
    FMT_BIN    = 2'b00,
    FMT_RSV    = 2'b01,
    FMT_TOD23  = 2'b10,
    FMT_TOD255 = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [EVT_SEL_W-1:0] evt_sel;
    logic                 cap_en;
    logic [SRC_W-1:0]     src_sel;
    logic [PSC_W-1:0]     psc;
    fmt_e                 fmt;
    logic                 periodic;
    logic                 up;
    logic                 enable;
  } ctl_t;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tod_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] sel,
  input  logic             xtal_clk,
  input  logic             pin_a,
  input  logic             pin_b,
  output logic             src_en
);
  localparam int EXT_N = 3;

  logic [EXT_N-1:0] ext_raw;
  logic [EXT_N-1:0] ext_edge;

  assign ext_raw = {pin_b, pin_a, xtal_clk};

  for (genvar gi = 0; gi < EXT_N; gi++) begin : g_sync
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-1:0], ext_raw[gi]};
    end
    assign ext_edge[gi] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  end

  always_comb begin
    unique case (sel)
      SRC_CORE: src_en = 1'b1;
      SRC_XTAL: src_en = ext_edge[0];
      SRC_PINA: src_en = ext_edge[1];
      SRC_PINB: src_en = ext_edge[2];
      default:  src_en = 1'b0;
    endcase
  end

  assert_ext_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && sel != SRC_CORE) |=> (!src_en || !$stable(sel)));

  assert_reserved_src_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel[2] |-> !src_en);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tod_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_en,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  logic [PSC_CNT_W-1:0] cnt;
  logic [PSC_CNT_W-1:0] mask;

  assign mask = (PSC_CNT_W'(1) << code) - PSC_CNT_W'(1);
  assign tick = run && src_en && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (src_en) cnt <= cnt + PSC_CNT_W'(1);
  end

  assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0) |=> (!tick || !$stable(code)));

  assert_idle_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tod_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             up,
  input  logic             periodic,
  input  fmt_e             fmt,
  input  logic             ld_we,
  input  logic [VAL_W-1:0] ld_wdata,
  input  logic [VAL_W-1:0] reload,
  output logic [VAL_W-1:0] value,
  output logic             term_hit
);
  localparam logic [7:0] HUND_MAX = 8'd99;
  localparam logic [7:0] SIX_MAX  = 8'd59;

  logic             tod;
  logic [7:0]       hr_max;
  logic [VAL_W-1:0] term_val;
  logic [VAL_W-1:0] bin_step;
  logic [VAL_W-1:0] tod_step;
  logic [VAL_W-1:0] nxt;

  assign tod    = fmt[1];
  assign hr_max = (fmt == FMT_TOD23) ? 8'd23 : 8'd255;

  always_comb begin
    if (tod) term_val = up ? {hr_max, SIX_MAX, SIX_MAX, HUND_MAX} : '0;
    else     term_val = up ? '1 : '0;
  end

  assign term_hit = tick && (value == term_val);
  assign bin_step = up ? value + VAL_W'(1) : value - VAL_W'(1);

  always_comb begin
    logic [7:0] f_c, f_s, f_m, f_h;
    logic       ca;
    f_c = value[7:0];
    f_s = value[15:8];
    f_m = value[23:16];
    f_h = value[31:24];
    if (up) begin
      ca = 1'b1;
      if (f_c >= HUND_MAX) f_c = 8'd0; else begin f_c = f_c + 8'd1; ca = 1'b0; end
      if (ca) begin
        if (f_s >= SIX_MAX) f_s = 8'd0; else begin f_s = f_s + 8'd1; ca = 1'b0; end
      end
      if (ca) begin
        if (f_m >= SIX_MAX) f_m = 8'd0; else begin f_m = f_m + 8'd1; ca = 1'b0; end
      end
      if (ca) begin
        if (f_h >= hr_max) f_h = 8'd0; else f_h = f_h + 8'd1;
      end
    end else begin
      ca = 1'b1;
      if (f_c == 8'd0) f_c = HUND_MAX; else begin f_c = f_c - 8'd1; ca = 1'b0; end
      if (ca) begin
        if (f_s == 8'd0) f_s = SIX_MAX; else begin f_s = f_s - 8'd1; ca = 1'b0; end
      end
      if (ca) begin
        if (f_m == 8'd0) f_m = SIX_MAX; else begin f_m = f_m - 8'd1; ca = 1'b0; end
      end
      if (ca) begin
        if (f_h == 8'd0) f_h = hr_max; else f_h = f_h - 8'd1;
      end
    end
    tod_step = {f_h, f_m, f_s, f_c};
  end

  always_comb begin
    if (term_hit && periodic) nxt = reload;
    else if (tod)             nxt = tod_step;
    else                      nxt = bin_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '1;
    else if (ld_we) value <= ld_wdata;
    else if (tick)  value <= nxt;
  end

  assert_tod_fields_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tod && !ld_we && !(term_hit && periodic) &&
     value[7:0] <= HUND_MAX && value[15:8] <= SIX_MAX && value[23:16] <= SIX_MAX)
    |=> (value[7:0] <= HUND_MAX && value[15:8] <= SIX_MAX && value[23:16] <= SIX_MAX));

  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (term_hit && periodic && !ld_we) |=> (value == $past(reload)));

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> (value == $past(ld_wdata)));
endmodule

// File: rtl/tod_timer.sv
module tod_timer
  import tod_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_we,
  input  logic [VAL_W-1:0]     ld_wdata,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic                 clri_we,
  input  logic                 cap_we,
  input  logic [VAL_W-1:0]     cap_wdata,
  input  logic                 xtal_clk,
  input  logic                 pin_a,
  input  logic                 pin_b,
  input  logic [EVT_N-1:0]     evt_in,
  output logic [VAL_W-1:0]     cur_val,
  output logic [VAL_W-1:0]     ld_val,
  output logic [CTL_W-1:0]     ctl_val,
  output logic [VAL_W-1:0]     cap_val,
  output logic                 irq
);
  ctl_t             ctl_q;
  logic [VAL_W-1:0] ld_q;
  logic [VAL_W-1:0] cap_q;
  logic             irq_q;
  logic             src_en;
  logic             tick;
  logic             term_hit;
  logic             evt_sel_bit;
  logic             evt_prev;
  logic             cap_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ld_q  <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
      if (ld_we)  ld_q  <= ld_wdata;
    end
  end

  tmr_src_sel #(.SYNC_STAGES(2)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ctl_q.src_sel),
    .xtal_clk (xtal_clk),
    .pin_a    (pin_a),
    .pin_b    (pin_b),
    .src_en   (src_en)
  );

  tmr_prescaler u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctl_q.enable),
    .src_en (src_en),
    .code   (ctl_q.psc),
    .tick   (tick)
  );

  tmr_count_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .up       (ctl_q.up),
    .periodic (ctl_q.periodic),
    .fmt      (ctl_q.fmt),
    .ld_we    (ld_we),
    .ld_wdata (ld_wdata),
    .reload   (ld_q),
    .value    (cur_val),
    .term_hit (term_hit)
  );

  assign evt_sel_bit = evt_in[ctl_q.evt_sel];
  assign cap_fire    = ctl_q.cap_en && evt_sel_bit && !evt_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev <= 1'b0;
      cap_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      evt_prev <= evt_sel_bit;
      if (cap_fire)    cap_q <= cur_val;
      else if (cap_we) cap_q <= cap_wdata;
      if (term_hit)     irq_q <= 1'b1;
      else if (clri_we) irq_q <= 1'b0;
    end
  end

  assign ld_val  = ld_q;
  assign ctl_val = CTL_W'(ctl_q);
  assign cap_val = cap_q;
  assign irq     = irq_q;

  assert_irq_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> irq);

  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clri_we && !term_hit) |=> !irq);

  assert_capture_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cap_val == $past(cur_val)));

  assert_cap_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.cap_en && !cap_we) |=> $stable(cap_val));

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.enable && !ld_we) |=> $stable(cur_val));
endmodule

// File: tb/tod_timer_bench.sv
module tod_timer_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [31:0] ld_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [17:0] ctl_wdata = '0;
  logic        clri_we = 1'b0;
  logic        cap_we = 1'b0;
  logic [31:0] cap_wdata = '0;
  logic        xtal_clk = 1'b0;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic [31:0] evt_in = '0;
  logic [31:0] cur_val;
  logic [31:0] ld_val;
  logic [17:0] ctl_val;
  logic [31:0] cap_val;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_timer u_tod_timer (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_wdata(ld_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .clri_we(clri_we),
    .cap_we(cap_we), .cap_wdata(cap_wdata), .xtal_clk(xtal_clk),
    .pin_a(pin_a), .pin_b(pin_b), .evt_in(evt_in), .cur_val(cur_val),
    .ld_val(ld_val), .ctl_val(ctl_val), .cap_val(cap_val), .irq(irq)
  );

  function automatic logic [17:0] mk(input logic en, input logic up, input logic per,
                                     input logic [1:0] fmt, input logic [3:0] psc,
                                     input logic [2:0] src, input logic cen,
                                     input logic [4:0] esel);
    return {esel, cen, src, psc, fmt, per, up, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [17:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_ld(input logic [31:0] v);
    @(negedge clk); ld_we = 1'b1; ld_wdata = v;
    @(negedge clk); ld_we = 1'b0;
  endtask

  task automatic wr_clri();
    @(negedge clk); clri_we = 1'b1;
    @(negedge clk); clri_we = 1'b0;
  endtask

  task automatic prep(input logic [31:0] v);
    wr_ctl('0);
    wr_ld(v);
    wr_clri();
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cur", cur_val, 32'hFFFF_FFFF);
    chk("R1 ld", ld_val, 32'h0);
    chk("R1 ctl", {14'h0, ctl_val}, 32'h0);
    chk("R1 cap", cap_val, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_load();
    prep(32'hCAFE_0123);
    chk("R2 ld readback", ld_val, 32'hCAFE_0123);
    chk("R2 cur loaded", cur_val, 32'hCAFE_0123);
  endtask

  task automatic t_bin_down_free();
    prep(32'd2);
    wr_ctl(mk(1, 0, 0, 2'b00, 4'd0, 3'd0, 0, 5'd0));
    wait_n(2);
    chk("R3 reach zero", cur_val, 32'd0);
    chk("R3 no irq before terminal", {31'h0, irq}, 32'h0);
    wait_n(1);
    chk("R3 wrap", cur_val, 32'hFFFF_FFFF);
    chk("R3 irq", {31'h0, irq}, 32'h1);
    wr_ctl('0);
  endtask

  task automatic t_up_periodic();
    prep(32'hFFFF_FFFE);
    wr_ctl(mk(1, 1, 1, 2'b00, 4'd0, 3'd0, 0, 5'd0));
    wait_n(1);
    chk("R4 step up", cur_val, 32'hFFFF_FFFF);
    wait_n(1);
    chk("R4 reload", cur_val, 32'hFFFF_FFFE);
    chk("R4 irq", {31'h0, irq}, 32'h1);
    wr_ctl('0);
  endtask

  task automatic t_down_periodic();
    prep(32'd3);
    wr_ctl(mk(1, 0, 1, 2'b00, 4'd0, 3'd0, 0, 5'd0));
    wait_n(3);
    chk("R5 zero", cur_val, 32'd0);
    wait_n(1);
    chk("R5 reload", cur_val, 32'd3);
    chk("R5 irq", {31'h0, irq}, 32'h1);
    wr_ctl('0);
  endtask

  task automatic t_prescale();
    prep(32'd100);
    wr_ctl(mk(1, 0, 0, 2'b00, 4'd4, 3'd0, 0, 5'd0));
    wait_n(15);
    chk("R6 before 16th", cur_val, 32'd100);
    wait_n(1);
    chk("R6 at 16th", cur_val, 32'd99);
    wait_n(16);
    chk("R6 at 32nd", cur_val, 32'd98);
    wr_ctl(mk(1, 0, 0, 2'b00, 4'd15, 3'd0, 0, 5'd0));
    wait_n(40);
    chk("R6 div 32768 no early tick", cur_val, 32'd98);
    wr_ctl('0);
  endtask

  task automatic t_hold();
    prep(32'h0000_0050);
    wr_ctl(mk(0, 1, 0, 2'b00, 4'd0, 3'd0, 0, 5'd0));
    wait_n(10);
    chk("R7 held", cur_val, 32'h0000_0050);
  endtask

  task automatic t_tod_down();
    prep(32'h0100_0000);
    wr_ctl(mk(1, 0, 0, 2'b10, 4'd0, 3'd0, 0, 5'd0));
    wait_n(1);
    chk("R8 borrow chain", cur_val, 32'h003B_3B63);
    wait_n(1);
    chk("R8 next", cur_val, 32'h003B_3B62);
    prep(32'h0000_0001);
    wr_ctl(mk(1, 0, 0, 2'b10, 4'd0, 3'd0, 0, 5'd0));
    wait_n(2);
    chk("R8 zero wraps to 23h max", cur_val, 32'h173B_3B63);
    chk("R8 irq", {31'h0, irq}, 32'h1);
    wr_ctl('0);
  endtask

  task automatic t_tod_up();
    prep(32'h173B_3B63);
    wr_ctl(mk(1, 1, 0, 2'b10, 4'd0, 3'd0, 0, 5'd0));
    wait_n(1);
    chk("R9 23h wrap", cur_val, 32'h0);
    chk("R9 23h irq", {31'h0, irq}, 32'h1);
    prep(32'h173B_3B63);
    wr_ctl(mk(1, 1, 0, 2'b11, 4'd0, 3'd0, 0, 5'd0));
    wait_n(1);
    chk("R9 255h continue", cur_val, 32'h1800_0000);
    chk("R9 255h no irq", {31'h0, irq}, 32'h0);
    prep(32'h0000_0062);
    wr_ctl(mk(1, 1, 0, 2'b10, 4'd0, 3'd0, 0, 5'd0));
    wait_n(2);
    chk("R9 hundredths carry", cur_val, 32'h0000_0100);
    wr_ctl('0);
  endtask

  task automatic t_reserved_fmt();
    prep(32'h0000_0063);
    wr_ctl(mk(1, 1, 0, 2'b01, 4'd0, 3'd0, 0, 5'd0));
    wait_n(1);
    chk("R13 binary step", cur_val, 32'h0000_0064);
    wr_ctl('0);
  endtask

  task automatic pulse_a();
    @(negedge clk); pin_a = 1'b1;
    wait_n(3);
    pin_a = 1'b0;
    wait_n(3);
  endtask

  task automatic pulse_b();
    @(negedge clk); pin_b = 1'b1;
    wait_n(3);
    pin_b = 1'b0;
    wait_n(3);
  endtask

  task automatic t_ext_pins();
    prep(32'd10);
    wr_ctl(mk(1, 0, 0, 2'b00, 4'd0, 3'd2, 0, 5'd0));
    wait_n(4);
    chk("R10 idle pin no count", cur_val, 32'd10);
    pulse_a();
    pulse_a();
    pulse_a();
    chk("R10 pin A edges", cur_val, 32'd7);
    pulse_b();
    chk("R10 pin B ignored", cur_val, 32'd7);
    wr_ctl(mk(1, 0, 0, 2'b00, 4'd0, 3'd3, 0, 5'd0));
    pulse_b();
    chk("R10 pin B edge", cur_val, 32'd6);
    wr_ctl(mk(1, 0, 0, 2'b00, 4'd0, 3'd4, 0, 5'd0));
    pulse_a();
    pulse_b();
    wait_n(5);
    chk("R10 reserved source", cur_val, 32'd6);
    wr_ctl('0);
  endtask

  task automatic pulse_evt(input int idx);
    @(negedge clk); evt_in[idx] = 1'b1;
    wait_n(2);
    evt_in[idx] = 1'b0;
    wait_n(1);
  endtask

  task automatic t_capture();
    prep(32'h0000_1234);
    wr_ctl(mk(0, 0, 0, 2'b00, 4'd0, 3'd0, 1, 5'd5));
    pulse_evt(3);
    chk("R11 unselected line", cap_val, 32'h0);
    pulse_evt(5);
    chk("R11 selected capture", cap_val, 32'h0000_1234);
    wr_ctl(mk(0, 0, 0, 2'b00, 4'd0, 3'd0, 0, 5'd5));
    wr_ld(32'h0000_0055);
    pulse_evt(5);
    chk("R11 capture disabled", cap_val, 32'h0000_1234);
    @(negedge clk); cap_we = 1'b1; cap_wdata = 32'hA5A5_0000;
    @(negedge clk); cap_we = 1'b0;
    chk("R11 capture write", cap_val, 32'hA5A5_0000);
  endtask

  task automatic t_irq();
    prep(32'd1);
    wr_ctl(mk(1, 0, 0, 2'b00, 4'd0, 3'd0, 0, 5'd0));
    @(negedge clk); clri_we = 1'b1;
    @(negedge clk); clri_we = 1'b0;
    chk("R12 set wins over clear", {31'h0, irq}, 32'h1);
    wr_ctl('0);
    wr_clri();
    chk("R12 cleared", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_load();
    t_bin_down_free();
    t_up_periodic();
    t_down_periodic();
    t_prescale();
    t_hold();
    t_tod_down();
    t_tod_up();
    t_reserved_fmt();
    t_ext_pins();
    t_capture();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule